// File: doc/BRIEF.md
# Modem Status Change Detector

This block produces the modem status byte of a serial port. It watches four active-low handshake inputs from a modem or other peripheral: clear to send, data set ready, ring indicator and carrier detect. The upper nibble of the byte gives the present state of each line, inverted so that 1 means asserted. The lower nibble holds sticky change flags. A flag is set when its line changes, and all four flags clear when the host reads the byte.

The ring flag does not react to every transition. It latches only when the ring line returns from asserted to idle, which is the trailing edge of a ring burst. In loopback mode the four status sources move from the pins to the request-to-send, terminal-ready and two general-purpose output bits of the modem control register. Change detection follows whichever source is selected.

An interrupt request is raised while any change flag is set and the modem status interrupt is enabled. Address decode is done outside the block. The read strobe is already qualified for this register, which is offset 6 and does not depend on the divisor latch access bit.

Top module: `mdm_status_reg`

## Requirements
- R1: Bit 0 (clear to send), bit 1 (data set ready) and bit 3 (carrier detect) each set to 1 on any transition of the selected source of that line. They stay at 1 until a read.
- R2: Bit 2 (ring) sets only when the selected active-low ring level goes from 0 to 1. A 1-to-0 transition leaves it unchanged.
- R3: On a clock edge with `rd_stb` high, bits 3:0 clear to 0. During that cycle `rd_data` still shows the value before the clear.
- R4: `irq` is 1 exactly when `irq_en` is 1 and at least one of bits 3:0 is 1. The output is combinational from the flags.
- R5: Outside loopback, bits 4, 5, 6 and 7 are the inverses of the synchronized clear-to-send, data-set-ready, ring and carrier-detect pins.
- R6: While `lpbk_en` is 1, bits 4, 5, 6 and 7 equal `ctl_rts`, `ctl_dtr`, `ctl_out1` and `ctl_out2`, with no delay. The pins then affect no bit. A control bit change sets its flag on the next clock edge.
- R7: A change event in the same cycle as a read strobe is not lost. The flag is 1 after that edge.
- R8: A pin change takes two clock edges to reach its status bit and three edges to set its flag.
- R9: After reset the pins are taken as deasserted (level 1), every flag is 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Clear to send pin, active low |
| dsr_n_pin | input | 1 | Data set ready pin, active low |
| ri_n_pin | input | 1 | Ring indicator pin, active low |
| dcd_n_pin | input | 1 | Carrier detect pin, active low |
| lpbk_en | input | 1 | Loopback select from the modem control register |
| ctl_rts | input | 1 | Request-to-send control bit |
| ctl_dtr | input | 1 | Terminal-ready control bit |
| ctl_out1 | input | 1 | General-purpose output 1 control bit |
| ctl_out2 | input | 1 | General-purpose output 2 control bit |
| rd_stb | input | 1 | One-cycle read strobe for this register |
| irq_en | input | 1 | Modem status interrupt enable |
| rd_data | output | 8 | Status byte: flags in 3:0, line states in 7:4 |
| irq | output | 1 | Modem status interrupt request |

## Verification
The bench drives the ring line through both directions. A detector that treats the leading edge as an event would raise bit 2 and the interrupt too early. It also checks the status bit one edge after a pin change, then again after the second edge, and checks the flag one edge later still. A shorter or longer synchronizer shows up as a wrong value at one of these sample points. A read strobe and a loopback control change are placed on the same edge; a design that lets the clear win drops the flag. While in loopback the pins are toggled, and the bench confirms the byte does not move.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int MDM_LINES = 4;
   // line positions inside the status nibbles; the ring line is special
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_DCD = 3;
   typedef logic [MDM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int   WIDTH   = 4,
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mdm_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("mdm_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stg[s] <= {WIDTH{RST_LVL}};
      end else begin
         stg[0] <= d_async;
         for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
      end
   end

   assign q_sync = stg[STAGES-1];
endmodule

// File: rtl/mdm_srcsel.sv
module mdm_srcsel #(
   parameter int WIDTH = 4
) (
   input  logic             lpbk_en,
   input  logic [WIDTH-1:0] pin_n,
   input  logic [WIDTH-1:0] ctl_hi,
   output logic [WIDTH-1:0] sel_n
);
   // control bits are active high; convert to the pins' active-low sense
   always_comb begin
      sel_n = lpbk_en ? ~ctl_hi : pin_n;
   end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
   parameter int               WIDTH      = 4,
   parameter logic [WIDTH-1:0] TRAIL_MASK = '0,
   parameter logic             RST_LVL    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_n,
   input  logic             clr,
   output logic [WIDTH-1:0] evt,
   output logic [WIDTH-1:0] flags
);
   logic [WIDTH-1:0] prev_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_n <= {WIDTH{RST_LVL}};
      else        prev_n <= lvl_n;
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_line
      if (TRAIL_MASK[i]) begin : g_trail
         // active-low level returning high: end of the asserted period
         assign evt[i] = ~prev_n[i] & lvl_n[i];
      end else begin : g_any
         assign evt[i] = prev_n[i] ^ lvl_n[i];
      end
   end

   // set has priority over the read clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= '0;
      else        flags <= (flags & ~{WIDTH{clr}}) | evt;
   end
endmodule

// File: rtl/mdm_status_reg.sv
module mdm_status_reg
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cts_n_pin,
   input  logic       dsr_n_pin,
   input  logic       ri_n_pin,
   input  logic       dcd_n_pin,
   input  logic       lpbk_en,
   input  logic       ctl_rts,
   input  logic       ctl_dtr,
   input  logic       ctl_out1,
   input  logic       ctl_out2,
   input  logic       rd_stb,
   input  logic       irq_en,
   output logic [7:0] rd_data,
   output logic       irq
);
   localparam int        DW         = 2 * MDM_LINES;
   localparam line_vec_t TRAIL_MASK = line_vec_t'(1) << LN_RI;

   if (DW != 8) begin : g_bad_dw
      $error("mdm_status_reg: status byte must be 8 bits");
   end

   line_vec_t pin_raw_n, pin_sync_n, ctl_vec, sel_n, evt_vec, flag_vec;

   always_comb begin
      pin_raw_n         = '1;
      pin_raw_n[LN_CTS] = cts_n_pin;
      pin_raw_n[LN_DSR] = dsr_n_pin;
      pin_raw_n[LN_RI]  = ri_n_pin;
      pin_raw_n[LN_DCD] = dcd_n_pin;
      ctl_vec           = '0;
      ctl_vec[LN_CTS]   = ctl_rts;
      ctl_vec[LN_DSR]   = ctl_dtr;
      ctl_vec[LN_RI]    = ctl_out1;
      ctl_vec[LN_DCD]   = ctl_out2;
   end

   mdm_sync #(.WIDTH(MDM_LINES), .STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async (pin_raw_n),
      .q_sync  (pin_sync_n)
   );

   mdm_srcsel #(.WIDTH(MDM_LINES)) u_sel (
      .lpbk_en (lpbk_en),
      .pin_n   (pin_sync_n),
      .ctl_hi  (ctl_vec),
      .sel_n   (sel_n)
   );

   mdm_delta #(.WIDTH(MDM_LINES), .TRAIL_MASK(TRAIL_MASK), .RST_LVL(1'b1)) u_delta (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_n (sel_n),
      .clr   (rd_stb),
      .evt   (evt_vec),
      .flags (flag_vec)
   );

   assign rd_data = {~sel_n, flag_vec};
   assign irq     = irq_en & (|flag_vec);
endmodule

// File: rtl/mdm_status_chk.sv
module mdm_status_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       rd_stb,
   input logic       irq_en,
   input logic       irq,
   input logic       lpbk_en,
   input logic       ctl_rts,
   input logic       ctl_dtr,
   input logic       ctl_out1,
   input logic       ctl_out2,
   input logic [3:0] evt_vec,
   input logic [7:0] rd_data
);
   AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (irq_en && rd_data[3:0] != 4'h0));                          // R4
   AST_IRQ_WHEN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en && rd_data[3:0] != 4'h0) |-> irq);                          // R4
   AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> ((rd_data[3:0] & $past(rd_data[3:0])) == $past(rd_data[3:0]))); // R1
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && evt_vec == 4'h0) |=> rd_data[3:0] == 4'h0);              // R3
   AST_READ_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && evt_vec[1]) |=> rd_data[1]);                             // R7
   AST_RING_LEAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd_stb && !rd_data[2] && $rose(rd_data[6]) && !lpbk_en && !$past(lpbk_en))
      |=> !rd_data[2]);                                                   // R2
   AST_LOOP_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
      lpbk_en |-> rd_data[7:4] == {ctl_out2, ctl_out1, ctl_dtr, ctl_rts}); // R6
endmodule

bind mdm_status_reg mdm_status_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_stb   (rd_stb),
   .irq_en   (irq_en),
   .irq      (irq),
   .lpbk_en  (lpbk_en),
   .ctl_rts  (ctl_rts),
   .ctl_dtr  (ctl_dtr),
   .ctl_out1 (ctl_out1),
   .ctl_out2 (ctl_out2),
   .evt_vec  (evt_vec),
   .rd_data  (rd_data)
);

// File: tb/sim_mdm_status_reg.sv
`timescale 1ns/1ps
module sim_mdm_status_reg;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cts_n_pin = 1'b1, dsr_n_pin = 1'b1, ri_n_pin = 1'b1, dcd_n_pin = 1'b1;
   logic lpbk_en = 1'b0;
   logic ctl_rts = 1'b0, ctl_dtr = 1'b0, ctl_out1 = 1'b0, ctl_out2 = 1'b0;
   logic rd_stb = 1'b0, irq_en = 1'b0;
   logic [7:0] rd_data;
   logic irq;
   int n_run = 0, n_fail = 0;

   always #4 clk = ~clk;

   mdm_status_reg u0 (
      .clk(clk), .rst_n(rst_n),
      .cts_n_pin(cts_n_pin), .dsr_n_pin(dsr_n_pin), .ri_n_pin(ri_n_pin), .dcd_n_pin(dcd_n_pin),
      .lpbk_en(lpbk_en), .ctl_rts(ctl_rts), .ctl_dtr(ctl_dtr), .ctl_out1(ctl_out1), .ctl_out2(ctl_out2),
      .rd_stb(rd_stb), .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_read(output logic [7:0] val);
      rd_stb = 1'b1;
      #1 val = rd_data;
      @(posedge clk);
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic t_reset;
      chk("R9 reset byte", rd_data, 8'h00);
      chk("R9 reset irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_sync_latency;
      logic [7:0] v;
      cts_n_pin = 1'b0;
      tick(1);
      chk("R8 status after one edge", {7'd0, rd_data[4]}, 8'h00);
      tick(1);
      chk("R8 R5 status after two edges", rd_data, 8'h10);
      tick(1);
      chk("R8 R1 flag after three edges", rd_data, 8'h11);
      chk("R4 irq masked", {7'd0, irq}, 8'h00);
      irq_en = 1'b1;
      #1 chk("R4 irq enabled", {7'd0, irq}, 8'h01);
      do_read(v);
      chk("R3 read returns pre-clear", v, 8'h11);
      chk("R3 flags cleared", rd_data, 8'h10);
      chk("R4 irq drops after read", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_other_lines;
      logic [7:0] v;
      dsr_n_pin = 1'b0;
      dcd_n_pin = 1'b0;
      tick(3);
      chk("R1 R5 dsr dcd assert", rd_data, 8'hBA);
      do_read(v);
      cts_n_pin = 1'b1;
      tick(3);
      chk("R1 cts release flags", rd_data, 8'hA1);
      do_read(v);
      chk("R3 cleared again", rd_data, 8'hA0);
   endtask

   task automatic t_ring;
      logic [7:0] v;
      ri_n_pin = 1'b0;
      tick(3);
      chk("R2 leading ring edge ignored", rd_data, 8'hE0);
      chk("R2 no irq on leading edge", {7'd0, irq}, 8'h00);
      ri_n_pin = 1'b1;
      tick(3);
      chk("R2 trailing ring edge latched", rd_data, 8'hA4);
      do_read(v);
   endtask

   task automatic t_loopback;
      logic [7:0] v;
      lpbk_en = 1'b1;
      tick(1);
      // pins had dsr and dcd asserted; loopback sources are idle
      chk("R6 entering loopback", rd_data, 8'h0A);
      do_read(v);
      ctl_rts = 1'b1;
      ctl_out2 = 1'b1;
      #1 chk("R6 immediate mirror", rd_data, 8'h90);
      tick(1);
      chk("R6 control change flags", rd_data, 8'h99);
      do_read(v);
      cts_n_pin = 1'b0;
      dsr_n_pin = 1'b1;
      dcd_n_pin = 1'b1;
      ri_n_pin = 1'b0;
      tick(4);
      chk("R6 pins ignored", rd_data, 8'h90);
      ctl_out1 = 1'b1;
      tick(1);
      chk("R6 R2 loop ring leading", rd_data, 8'hD0);
      ctl_out1 = 1'b0;
      tick(1);
      chk("R6 R2 loop ring trailing", rd_data, 8'h94);
      do_read(v);
   endtask

   task automatic t_race;
      rd_stb = 1'b1;
      ctl_dtr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_stb = 1'b0;
      chk("R7 event survives read", rd_data, 8'hB2);
      irq_en = 1'b0;
      #1 chk("R4 irq gated off", {7'd0, irq}, 8'h00);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      t_reset();
      t_sync_latency();
      t_other_lines();
      t_ring();
      t_loopback();
      t_race();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule